// File: doc/BRIEF.md
# Programmable Address Window Decoder

The decoder sorts each incoming bus address into one of a small set of programmable windows and reports which target the address belongs to. Each window holds a base page, a size mask, a target identifier, an attribute code and an enable bit. Sizes are powers of two in 64 KB steps. A size value is legal only when its set bits form one unbroken run that starts at bit 0. Each set bit doubles the window, so 0x0000 gives 64 KB, 0x00FF gives 16 MB and 0x07FF gives 128 MB.

Software programs the windows through a single-cycle write port. A write selects one window and one field. The field codes are:

| cfg_field | Field |
|-----------|-------|
| 0 | base page |
| 1 | size mask |
| 2 | target and attribute |
| 3 | enable |

Only address bits 31:16 reach the decoder, because nothing finer than a 64 KB page can change the result. When more than one window matches, the lowest-numbered window wins. Writing a size that is not a clean run of ones latches a sticky error bit for that window. That window then stays out of decoding until reset.

Top module: `awd_decoder`

## Requirements
- R1: Reset clears every window to disabled with no error. For the first cycle after reset, hit and miss are 0 and target and attribute are 0.
- R2: An enabled, error-free window matches page P when the bits of P outside the size mask equal the bits of the base page outside the mask. Base bits under the mask have no effect.
- R3: A size of 0x0000 matches exactly one 64 KB page.
- R4: A size of 0x00FF spans 256 pages (16 MB), and a size of 0x07FF spans 2048 pages (128 MB). Both are aligned down to their own size.
- R5: When several windows match, the outputs carry the target and attribute of the lowest-numbered one.
- R6: When a valid address matches no window, miss is 1, hit is 0, and target and attribute are 0. hit and miss are never both 1.
- R7: A size write whose value is not a run of ones from bit 0 sets that window's bit in win_err. The bit stays set until reset, even after a later legal size write. While it is set, the window never matches.
- R8: The result for an address with addr_valid high appears on the outputs one clock later. A cycle with addr_valid low yields hit = miss = 0 one clock later.
- R9: A window whose enable is 0 never matches. Setting the enable makes it match with no other change.
- R10: Write port field codes: 0 stores cfg_wdata[31:16] as the base page; 1 stores cfg_wdata[15:0] as the size; 2 stores cfg_wdata[3:0] as the target and cfg_wdata[11:4] as the attribute; 3 stores cfg_wdata[0] as the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | Address strobe |
| addr_page | input | 16 | Address bits 31:16 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window index for the write |
| cfg_field | input | 2 | Field select for the write (see R10) |
| cfg_wdata | input | 32 | Write data |
| hit | output | 1 | Registered: address fell in a window |
| miss | output | 1 | Registered: valid address matched no window |
| target | output | 4 | Target of the winning window, 0 otherwise |
| attr | output | 8 | Attribute of the winning window, 0 otherwise |
| win_err | output | 6 | Sticky illegal-size flag per window |

## Verification
The bench programs overlapping, single-page, disabled and illegal windows. It then sweeps all 65536 pages against a model that reasons in page ranges rather than masks. A wrong mask polarity or an off-by-one in the run length would shift window edges, and the edge pages around 0x17FF/0x1800 and 0x18FF/0x1900 expose it. A priority encoder that favoured the highest index would return window 3's target inside windows 0 and 1. An error flag that cleared on a later legal write would let the broken window answer at page 0x2000. A decoder that ignored addr_valid would produce a stale hit after an idle cycle.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int AWD_PAGE_W = 16;
  typedef logic [AWD_PAGE_W-1:0] awd_page_t;

  // legal when adding one clears every set bit: a run of ones from bit 0
  function automatic logic size_is_run(input awd_page_t sz);
    return ((sz + awd_page_t'(1)) & sz) == '0;
  endfunction

  // page matches when it agrees with the base outside the size mask
  function automatic logic page_in_window(input awd_page_t page,
                                          input awd_page_t base,
                                          input awd_page_t sz);
    return ((page ^ base) & ~sz) == '0;
  endfunction
endpackage

// File: rtl/awd_window.sv
module awd_window
  import awd_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int IDX_W  = 3,
  parameter int TGT_W  = 4,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_field,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  awd_page_t         page,
  output logic              match,
  output logic [TGT_W-1:0]  tgt,
  output logic [ATTR_W-1:0] attr,
  output logic              err
);
  localparam int ATTR_LSB = TGT_W;

  awd_page_t         base_q, size_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [ATTR_W-1:0] attr_q;
  logic              en_q, err_q;
  logic              sel;

  assign sel = cfg_we && (cfg_win == IDX_W'(IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      tgt_q  <= '0;
      attr_q <= '0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (sel) begin
      case (cfg_field)
        2'd0: base_q <= cfg_wdata[DATA_W-1 -: AWD_PAGE_W];
        2'd1: begin
          size_q <= cfg_wdata[AWD_PAGE_W-1:0];
          if (!size_is_run(cfg_wdata[AWD_PAGE_W-1:0])) err_q <= 1'b1;
        end
        2'd2: begin
          tgt_q  <= cfg_wdata[TGT_W-1:0];
          attr_q <= cfg_wdata[ATTR_LSB +: ATTR_W];
        end
        default: en_q <= cfg_wdata[0];
      endcase
    end
  end

  assign match = en_q && !err_q && page_in_window(page, base_q, size_q);
  assign tgt   = tgt_q;
  assign attr  = attr_q;
  assign err   = err_q;
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !found;
      found  = found || req[i];
    end
    any = found;
  end
endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_valid,
  input  logic [AWD_PAGE_W-1:0] addr_page,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_win,
  input  logic [1:0]            cfg_field,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic                  hit,
  output logic                  miss,
  output logic [TGT_W-1:0]      target,
  output logic [ATTR_W-1:0]     attr,
  output logic [NUM_WIN-1:0]    win_err
);
  logic [NUM_WIN-1:0] match_vec, grant_vec;
  logic               any_match;
  logic [TGT_W-1:0]   tgt_w  [NUM_WIN];
  logic [ATTR_W-1:0]  attr_w [NUM_WIN];
  logic [TGT_W-1:0]   tgt_sel;
  logic [ATTR_W-1:0]  attr_sel;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    awd_window #(
      .IDX(i), .IDX_W(IDX_W), .TGT_W(TGT_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)
    ) u_win (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field),
      .cfg_wdata(cfg_wdata), .page(addr_page),
      .match(match_vec[i]), .tgt(tgt_w[i]), .attr(attr_w[i]), .err(win_err[i])
    );
  end

  awd_prio #(.N(NUM_WIN)) u_prio (
    .req(match_vec), .gnt(grant_vec), .any(any_match)
  );

  always_comb begin
    tgt_sel  = '0;
    attr_sel = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant_vec[i]) begin
        tgt_sel  = tgt_sel  | tgt_w[i];
        attr_sel = attr_sel | attr_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit    <= 1'b0;
      miss   <= 1'b0;
      target <= '0;
      attr   <= '0;
    end else begin
      hit    <= addr_valid && any_match;
      miss   <= addr_valid && !any_match;
      target <= (addr_valid && any_match) ? tgt_sel  : '0;
      attr   <= (addr_valid && any_match) ? attr_sel : '0;
    end
  end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN = 6,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               addr_valid,
  input logic               cfg_we,
  input logic [IDX_W-1:0]   cfg_win,
  input logic [1:0]         cfg_field,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               hit,
  input logic               miss,
  input logic [TGT_W-1:0]   target,
  input logic [ATTR_W-1:0]  attr,
  input logic [NUM_WIN-1:0] win_err,
  input logic [NUM_WIN-1:0] match_vec,
  input logic [NUM_WIN-1:0] grant_vec
);
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (target == '0 && attr == '0 && !hit)); // R6
  AST_VALID_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (hit || miss)); // R8
  AST_IDLE_GIVES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> (!hit && !miss)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~win_err) & $past(win_err)) == '0); // R7
  AST_BAD_SIZE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 2'd1 && 32'(cfg_win) < NUM_WIN &&
     !awd_pkg::size_is_run(cfg_wdata[15:0])) |=> win_err[$past(cfg_win)]); // R7
  AST_ERR_WIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & win_err) == '0); // R7
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R5
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (((grant_vec - 1'b1) & match_vec) == '0) && ((grant_vec & ~match_vec) == '0)); // R5
endmodule

bind awd_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_awd_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
  .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
  .hit(hit), .miss(miss), .target(target), .attr(attr), .win_err(win_err),
  .match_vec(match_vec), .grant_vec(grant_vec)
);

// File: tb/test_awd_decoder.sv
module test_awd_decoder;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic [15:0] addr_page = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hit, miss;
  logic [3:0]  target;
  logic [7:0]  attr;
  logic [5:0]  win_err;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] sh_base [NW];
  logic [15:0] sh_size [NW];
  logic [3:0]  sh_tgt  [NW];
  logic [7:0]  sh_attr [NW];
  logic        sh_en   [NW];
  logic        sh_err  [NW];

  always #10 clk = ~clk;

  awd_decoder i_awd_decoder (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_page(addr_page),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .hit(hit), .miss(miss), .target(target), .attr(attr), .win_err(win_err)
  );

  function automatic bit legal_size(input logic [15:0] s);
    bit zero_seen = 0;
    for (int b = 0; b < 16; b++) begin
      if (s[b] && zero_seen) return 0;
      if (!s[b]) zero_seen = 1;
    end
    return 1;
  endfunction

  // page-range model: window covers [aligned base, aligned base + 2^ones)
  task automatic model(input int page, output bit e_hit, output int e_tgt, output int e_attr);
    e_hit = 0; e_tgt = 0; e_attr = 0;
    for (int w = 0; w < NW; w++) begin
      if (sh_en[w] && !sh_err[w] && !e_hit) begin
        int n, lo;
        n = $countones(sh_size[w]);
        lo = (int'(sh_base[w]) / (1 << n)) * (1 << n);
        if (page >= lo && page < lo + (1 << n)) begin
          e_hit = 1; e_tgt = sh_tgt[w]; e_attr = sh_attr[w];
        end
      end
    end
  endtask

  task automatic check(input string tag, input bit e_hit, input bit e_miss,
                       input int e_tgt, input int e_attr);
    n_cmp++;
    if (hit !== e_hit || miss !== e_miss || int'(target) != e_tgt || int'(attr) != e_attr) begin
      n_bad++;
      $display("FAIL %s: got hit=%0b miss=%0b tgt=%0h attr=%0h, expected hit=%0b miss=%0b tgt=%0h attr=%0h",
               tag, hit, miss, target, attr, e_hit, e_miss, e_tgt, e_attr);
    end
  endtask

  task automatic check_err(input string tag, input logic [5:0] exp);
    n_cmp++;
    if (win_err !== exp) begin
      n_bad++;
      $display("FAIL %s: win_err got %b expected %b", tag, win_err, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < NW; w++) begin
      sh_base[w] = '0; sh_size[w] = '0; sh_tgt[w] = '0;
      sh_attr[w] = '0; sh_en[w] = 0; sh_err[w] = 0;
    end
  endtask

  task automatic cfg(input int w, input int fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_field = 2'(fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (fld)
      0: sh_base[w] = d[31:16];
      1: begin sh_size[w] = d[15:0]; if (!legal_size(d[15:0])) sh_err[w] = 1; end
      2: begin sh_tgt[w] = d[3:0]; sh_attr[w] = d[11:4]; end
      default: sh_en[w] = d[0];
    endcase
  endtask

  task automatic setup_win(input int w, input int base, input int sz, input int ta, input bit en);
    cfg(w, 0, 32'(base) << 16);
    cfg(w, 1, 32'(sz));
    cfg(w, 2, 32'(ta));
    cfg(w, 3, {31'd0, en});
  endtask

  // drive one address, look one clock later (R8 latency)
  task automatic lookup(input string tag, input int page, input bit e_hit,
                        input int e_tgt, input int e_attr);
    @(negedge clk);
    addr_valid = 1'b1; addr_page = 16'(page);
    @(negedge clk);
    addr_valid = 1'b0;
    check(tag, e_hit, !e_hit, e_tgt, e_attr);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 reset outputs", 0, 0, 0, 0);
    check_err("R1 reset err", 6'b0);
    lookup("R1 no window after reset", 16'h1000, 0, 0, 0);

    setup_win(0, 16'h1000, 16'h07FF, 12'h111, 1);
    setup_win(1, 16'h1800, 16'h00FF, 12'h222, 1);
    setup_win(2, 16'h3456, 16'h0000, 12'h333, 1);
    setup_win(3, 16'h1800, 16'h0FFF, 12'h444, 1);
    setup_win(4, 16'hF000, 16'h0FFF, 12'h555, 0);
    setup_win(5, 16'h2000, 16'h0101, 12'h666, 1);
    check_err("R7 illegal size flagged", 6'b100000);

    lookup("R3 single page", 16'h3456, 1, 3, 8'h33);
    lookup("R3 next page misses", 16'h3457, 0, 0, 0);
    lookup("R3 previous page misses", 16'h3455, 0, 0, 0);
    lookup("R4 128MB top edge", 16'h17FF, 1, 1, 8'h11);
    lookup("R4 16MB low edge", 16'h1800, 1, 2, 8'h22);
    lookup("R4 16MB top edge", 16'h18FF, 1, 2, 8'h22);
    lookup("R5 lower window beats overlap", 16'h1200, 1, 1, 8'h11);
    lookup("R5 overlap beyond lower window", 16'h1900, 1, 4, 8'h44);
    lookup("R9 disabled window", 16'hF100, 0, 0, 0);
    lookup("R7 errored window silent", 16'h2000, 0, 0, 0);
    lookup("R6 miss zeroes outputs", 16'h0000, 0, 0, 0);

    // R8: idle cycle after a hit gives neither hit nor miss
    lookup("R8 valid hit", 16'h1000, 1, 1, 8'h11);
    @(negedge clk);
    check("R8 idle cycle", 0, 0, 0, 0);

    // R2 / R6 sweep of every page, one address per cycle, result one clock later
    begin
      bit first = 1;
      int prev = 0;
      for (int p = 0; p <= 16'hFFFF + 1; p++) begin
        @(negedge clk);
        if (!first) begin
          bit eh; int et, ea;
          model(prev, eh, et, ea);
          check(eh ? "R2 sweep hit" : "R6 sweep miss", eh, !eh, et, ea);
        end
        first = 0;
        prev = p;
        addr_valid = (p <= 16'hFFFF);
        addr_page = 16'(p);
      end
      addr_valid = 1'b0;
    end

    // R9: enabling window 4 makes it answer
    cfg(4, 3, 32'd1);
    lookup("R9 enabled window hits", 16'hF100, 1, 5, 8'h55);
    // R2: base bits under the mask do not move the window
    cfg(2, 0, 32'h3457_0000);
    cfg(2, 1, 32'h0001);
    lookup("R2 masked base bit", 16'h3456, 1, 3, 8'h33);
    // R10: attribute field position
    cfg(2, 2, 32'h0000_0A57);
    lookup("R10 target/attr fields", 16'h3457, 1, 7, 8'hA5);

    // R7: legal rewrite does not clear the flag
    cfg(5, 1, 32'h0000);
    check_err("R7 err sticky", 6'b100000);
    lookup("R7 still silent", 16'h2000, 0, 0, 0);

    do_reset();
    @(negedge clk);
    check_err("R1 reset clears err", 6'b0);
    lookup("R1 windows cleared", 16'h1000, 0, 0, 0);

    finish_run();
  end
endmodule